// File: doc/BRIEF.md
# SHA-512 Instruction Decode and Execute Unit

This unit accepts one 32-bit instruction word at a time, qualified by a valid strobe. It recognises two encoding groups of hash instructions: a three-operand group and a two-operand group. For a legal instruction it reads its operands from a local bank of 32 vector registers, each 128 bits wide. It then applies one SHA-512 round step or one message-schedule step and writes the 128-bit result back over the destination register. The destination register is always an input as well as the output.

Each register holds two 64-bit lanes: lane 0 is bits 63:0 and lane 1 is bits 127:64. Two enables gate legality. One says the SHA-512 feature is present. The other says vector/floating-point access is permitted. Any word outside both groups is flagged as foreign, so that a neighbouring decoder can take it.

A test port preloads any register at a clock edge and reads any register combinationally. Each accepted instruction takes two clock edges. Exactly one of four outcome pulses follows: completion, undefined, access trap, or foreign.

Top module: `sha512_exec`

## Requirements
- R1: A word is in the three-operand group when (insn & 0xFFE0B000) == 0xCE608000. In that group the fields are: second source index at bits 20:16, option bit at 14, opcode at 11:10, first source index at 9:5 and destination index at 4:0.
- R2: A word is in the two-operand group when (insn & 0xFFFFF000) == 0xCEC08000. In that group the opcode is at bits 11:10, the source index at 9:5 and the destination index at 4:0. Opcode 0 is schedule step 0: d0' = d0 + s0(d1) and d1' = d1 + s0(n0).
- R3: Three-operand group, option 0, opcode 0 (round step H): d1' = d1 + S1(m1) + Ch(m1,n0,n1); then t = d1' + m0 and d0' = d0 + S1(t) + Ch(t,m1,n0). Here Ch(x,y,z) = (x&(y^z))^z, S1 = ror14^ror18^ror41, and done pulses.
- R4: Three-operand group, option 0, opcode 1 (round step H2): d1' = d1 + S0(m0) + Maj(n0,m1,m0); then d0' = d0 + S0(d1') + Maj(d1',m0,m1). Here S0 = ror28^ror34^ror39 and Maj is the bitwise majority.
- R5: Three-operand group, option 0, opcode 2 (schedule step 1): each lane i becomes di + s1(ni) + mi, where s1 = ror19^ror61^shr6.
- R6: The two-operand schedule step 0 uses s0 = ror1^ror8^shr7 and reads only the destination and the one source.
- R7: Three-operand opcode 3, any three-operand word with the option bit set, and two-operand opcodes 1 to 3 each raise undef. No register is written.
- R8: With feat_en low, every word of either group raises undef and writes no register.
- R9: A legal word with feat_en high but simd_ok low raises trap and writes no register. Undef takes precedence over trap.
- R10: A word in neither group raises not_mine only and writes no register.
- R11: Out of reset, busy and all outcome pulses are low. A word is taken only while busy is low. busy is high for the single cycle after acceptance. The outcome pulse and the register write appear after the second edge and last one cycle. A word offered while busy is ignored.
- R12: All operands are read at acceptance. When the destination aliases a source, every operand uses the old register value.
- R13: The test port writes tp_wdata to register tp_addr on an edge where tp_we is high. tp_rdata always shows register tp_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is offered |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | SHA-512 feature present |
| simd_ok | input | 1 | Vector register access permitted |
| tp_we | input | 1 | Test port write enable |
| tp_addr | input | 5 | Test port register index |
| tp_wdata | input | 128 | Test port write data |
| tp_rdata | output | 128 | Test port read data |
| busy | output | 1 | An instruction is executing |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined-instruction pulse |
| trap | output | 1 | Access-trap pulse |
| not_mine | output | 1 | Word belongs to neither group |

## Verification
A corrupted captured outcome shows up two edges after acceptance: the wrong pulse fires, or the destination changes when it must not. A corrupted captured operand or opcode appears in the destination at that same edge and is visible through the test port at once. A stuck busy register either blocks the next acceptance or lets a word slip in while busy. A word that slips in produces an extra pulse, or a write to a register that must stay unchanged, within three cycles.

// File: rtl/sha512_pkg.sv
package sha512_pkg;

    localparam int LANE_W    = 64;
    localparam int LANES     = 2;
    localparam int VEC_W     = LANE_W * LANES;
    localparam int RIDX_W    = 5;
    localparam int NUM_VREGS = 1 << RIDX_W;
    localparam int RD_PORTS  = 4;

    localparam logic [31:0] TRI_MASK  = 32'hFFE0_B000;
    localparam logic [31:0] TRI_MATCH = 32'hCE60_8000;
    localparam logic [31:0] DUO_MASK  = 32'hFFFF_F000;
    localparam logic [31:0] DUO_MATCH = 32'hCEC0_8000;
    localparam int          OPT_BIT   = 14;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        OP_RND_H  = 2'd0,
        OP_RND_H2 = 2'd1,
        OP_SCH_1  = 2'd2,
        OP_SCH_0  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        OUT_NONE    = 3'd0,
        OUT_DONE    = 3'd1,
        OUT_UNDEF   = 3'd2,
        OUT_TRAP    = 3'd3,
        OUT_FOREIGN = 3'd4
    } outcome_e;

    typedef struct packed {
        logic  hit;
        logic  alloc;
        logic  uses_m;
        op_e   op;
        ridx_t rd;
        ridx_t rn;
        ridx_t rm;
    } dec_t;

    typedef struct packed {
        outcome_e outcome;
        op_e      op;
        ridx_t    rd;
        vec_t     d;
        vec_t     n;
        vec_t     m;
    } stage_t;

    function automatic lane_t rotr(lane_t x, int unsigned s);
        return (x >> s) | (x << (LANE_W - s));
    endfunction

    function automatic lane_t big_sig0(lane_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    function automatic lane_t big_sig1(lane_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    function automatic lane_t small_sig0(lane_t x);
        return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
    endfunction

    function automatic lane_t small_sig1(lane_t x);
        return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
    endfunction

    function automatic lane_t choose(lane_t x, lane_t y, lane_t z);
        return (x & (y ^ z)) ^ z;
    endfunction

    function automatic lane_t majority(lane_t x, lane_t y, lane_t z);
        return (x & y) | ((x | y) & z);
    endfunction

endpackage

// File: rtl/sha512_decode.sv
module sha512_decode
    import sha512_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);
    logic       tri_hit;
    logic       duo_hit;
    logic [1:0] opc;
    logic       opt;

    always_comb begin
        tri_hit = (insn_i & TRI_MASK) == TRI_MATCH;
        duo_hit = (insn_i & DUO_MASK) == DUO_MATCH;
        opc     = insn_i[11:10];
        opt     = insn_i[OPT_BIT];

        dec_o.hit    = tri_hit | duo_hit;
        dec_o.alloc  = 1'b0;
        dec_o.uses_m = tri_hit;
        dec_o.op     = OP_RND_H;
        dec_o.rd     = insn_i[4:0];
        dec_o.rn     = insn_i[9:5];
        dec_o.rm     = insn_i[20:16];

        if (tri_hit) begin
            if (!opt && opc != 2'd3) begin
                dec_o.alloc = 1'b1;
                dec_o.op    = op_e'(opc);
            end
        end else if (duo_hit) begin
            dec_o.op = OP_SCH_0;
            if (opc == 2'd0) begin
                dec_o.alloc = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sha512_vrf.sv
module sha512_vrf #(
    parameter  int DEPTH  = 32,
    parameter  int WIDTH  = 128,
    parameter  int RPORTS = 4,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [WIDTH-1:0]             wdata,
    input  logic [RPORTS-1:0][AW-1:0]    raddr,
    output logic [RPORTS-1:0][WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < RPORTS; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/sha512_alu.sv
module sha512_alu
    import sha512_pkg::*;
(
    input  op_e  op_i,
    input  vec_t d_i,
    input  vec_t n_i,
    input  vec_t m_i,
    output vec_t res_o
);
    lane_t d0, d1, n0, n1, m0, m1;
    lane_t hi, lo, t;

    always_comb begin
        {d1, d0} = d_i;
        {n1, n0} = n_i;
        {m1, m0} = m_i;
        hi = d1;
        lo = d0;
        t  = '0;
        unique case (op_i)
            OP_RND_H: begin
                hi = d1 + big_sig1(m1) + choose(m1, n0, n1);
                t  = hi + m0;
                lo = d0 + big_sig1(t) + choose(t, m1, n0);
            end
            OP_RND_H2: begin
                hi = d1 + big_sig0(m0) + majority(n0, m1, m0);
                lo = d0 + big_sig0(hi) + majority(hi, m0, m1);
            end
            OP_SCH_1: begin
                lo = d0 + small_sig1(n0) + m0;
                hi = d1 + small_sig1(n1) + m1;
            end
            OP_SCH_0: begin
                lo = d0 + small_sig0(d1);
                hi = d1 + small_sig0(n0);
            end
            default: ;
        endcase
        res_o = {hi, lo};
    end
endmodule

// File: rtl/sha512_exec.sv
module sha512_exec
    import sha512_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [31:0]       insn,
    input  logic              feat_en,
    input  logic              simd_ok,
    input  logic              tp_we,
    input  logic [RIDX_W-1:0] tp_addr,
    input  logic [VEC_W-1:0]  tp_wdata,
    output logic [VEC_W-1:0]  tp_rdata,
    output logic              busy,
    output logic              done,
    output logic              undef,
    output logic              trap,
    output logic              not_mine
);
    dec_t     dec;
    outcome_e verdict;
    stage_t   s1_q;
    logic     busy_q;
    logic     accept;
    logic     wb_en;
    vec_t     alu_res;

    logic [RD_PORTS-1:0][RIDX_W-1:0] rd_addr;
    logic [RD_PORTS-1:0][VEC_W-1:0]  rd_data;
    logic  vrf_we;
    ridx_t vrf_waddr;
    vec_t  vrf_wdata;

    sha512_decode u_dec (
        .insn_i (insn),
        .dec_o  (dec)
    );

    // Legality order: group match, allocation and feature, then access.
    always_comb begin
        if (!dec.hit) begin
            verdict = OUT_FOREIGN;
        end else if (!dec.alloc || !feat_en) begin
            verdict = OUT_UNDEF;
        end else if (!simd_ok) begin
            verdict = OUT_TRAP;
        end else begin
            verdict = OUT_DONE;
        end
    end

    assign accept = insn_valid & ~busy_q;

    assign rd_addr[0] = dec.rd;
    assign rd_addr[1] = dec.rn;
    assign rd_addr[2] = dec.rm;
    assign rd_addr[3] = tp_addr;

    sha512_vrf #(
        .DEPTH  (NUM_VREGS),
        .WIDTH  (VEC_W),
        .RPORTS (RD_PORTS)
    ) u_vrf (
        .clk   (clk),
        .we    (vrf_we),
        .waddr (vrf_waddr),
        .wdata (vrf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    sha512_alu u_alu (
        .op_i  (s1_q.op),
        .d_i   (s1_q.d),
        .n_i   (s1_q.n),
        .m_i   (s1_q.m),
        .res_o (alu_res)
    );

    assign wb_en     = busy_q && (s1_q.outcome == OUT_DONE);
    assign vrf_we    = wb_en | tp_we;
    assign vrf_waddr = wb_en ? s1_q.rd : tp_addr;
    assign vrf_wdata = wb_en ? alu_res : tp_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            s1_q     <= '0;
            done     <= 1'b0;
            undef    <= 1'b0;
            trap     <= 1'b0;
            not_mine <= 1'b0;
        end else begin
            done     <= 1'b0;
            undef    <= 1'b0;
            trap     <= 1'b0;
            not_mine <= 1'b0;
            if (busy_q) begin
                busy_q   <= 1'b0;
                done     <= (s1_q.outcome == OUT_DONE);
                undef    <= (s1_q.outcome == OUT_UNDEF);
                trap     <= (s1_q.outcome == OUT_TRAP);
                not_mine <= (s1_q.outcome == OUT_FOREIGN);
            end else if (accept) begin
                busy_q       <= 1'b1;
                s1_q.outcome <= verdict;
                s1_q.op      <= dec.op;
                s1_q.rd      <= dec.rd;
                if (verdict == OUT_DONE) begin
                    s1_q.d <= rd_data[0];
                    s1_q.n <= rd_data[1];
                    s1_q.m <= dec.uses_m ? rd_data[2] : '0;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign tp_rdata = rd_data[3];
endmodule

// File: rtl/sha512_exec_chk.sv
module sha512_exec_chk (
    input logic clk,
    input logic rst,
    input logic insn_valid,
    input logic busy,
    input logic done,
    input logic undef,
    input logic trap,
    input logic not_mine,
    input logic wb_en
);
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, undef, trap, not_mine}));

    a_r11_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !busy) |=> busy);

    a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r11_outcome_after_busy: assert property (@(posedge clk) disable iff (rst)
        (done || undef || trap || not_mine) |-> $past(busy));

    a_r11_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_wrote: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wb_en));

    a_r9_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        (undef || trap || not_mine) |-> !$past(wb_en));
endmodule

bind sha512_exec sha512_exec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .busy       (busy),
    .done       (done),
    .undef      (undef),
    .trap       (trap),
    .not_mine   (not_mine),
    .wb_en      (wb_en)
);

// File: tb/sha512_exec_test.sv
`timescale 1ns/1ps
module sha512_exec_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         insn_valid;
    logic [31:0]  insn;
    logic         feat_en;
    logic         simd_ok;
    logic         tp_we;
    logic [4:0]   tp_addr;
    logic [127:0] tp_wdata;
    logic [127:0] tp_rdata;
    logic         busy, done, undef, trap, not_mine;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sha512_exec uut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
        .feat_en(feat_en), .simd_ok(simd_ok), .tp_we(tp_we), .tp_addr(tp_addr),
        .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .busy(busy), .done(done),
        .undef(undef), .trap(trap), .not_mine(not_mine)
    );

    localparam logic [3:0] F_DONE = 4'b1000, F_UNDEF = 4'b0100,
                           F_TRAP = 4'b0010, F_FOREIGN = 4'b0001, F_NONE = 4'b0000;

    // ---- reference model from the requirements ----
    function automatic logic [63:0] ror(logic [63:0] x, int s);
        logic [127:0] w = {x, x} >> s;
        return w[63:0];
    endfunction
    function automatic logic [63:0] cs0(logic [63:0] x); return ror(x,28)^ror(x,34)^ror(x,39); endfunction
    function automatic logic [63:0] cs1(logic [63:0] x); return ror(x,14)^ror(x,18)^ror(x,41); endfunction
    function automatic logic [63:0] ls0(logic [63:0] x); return ror(x,1)^ror(x,8)^(x>>7); endfunction
    function automatic logic [63:0] ls1(logic [63:0] x); return ror(x,19)^ror(x,61)^(x>>6); endfunction
    function automatic logic [63:0] fch(logic [63:0] x, y, z); return (x & y) | (~x & z); endfunction
    function automatic logic [63:0] fmj(logic [63:0] x, y, z); return (x&y)^(x&z)^(y&z); endfunction

    function automatic logic [127:0] model(int kind, logic [127:0] d, n, m);
        logic [63:0] a0, a1, t;
        case (kind)
            0: begin
                a1 = d[127:64] + cs1(m[127:64]) + fch(m[127:64], n[63:0], n[127:64]);
                t  = a1 + m[63:0];
                a0 = d[63:0] + cs1(t) + fch(t, m[127:64], n[63:0]);
            end
            1: begin
                a1 = d[127:64] + cs0(m[63:0]) + fmj(n[63:0], m[127:64], m[63:0]);
                a0 = d[63:0] + cs0(a1) + fmj(a1, m[63:0], m[127:64]);
            end
            2: begin
                a0 = d[63:0] + ls1(n[63:0]) + m[63:0];
                a1 = d[127:64] + ls1(n[127:64]) + m[127:64];
            end
            default: begin
                a0 = d[63:0] + ls0(d[127:64]);
                a1 = d[127:64] + ls0(n[63:0]);
            end
        endcase
        return {a1, a0};
    endfunction

    function automatic logic [31:0] enc3(bit o, logic [1:0] opc, logic [4:0] rm, rn, rd);
        return 32'hCE60_8000 | ({27'd0, rm} << 16) | ({31'd0, o} << 14)
             | ({30'd0, opc} << 10) | ({27'd0, rn} << 5) | {27'd0, rd};
    endfunction
    function automatic logic [31:0] enc2(logic [1:0] opc, logic [4:0] rn, rd);
        return 32'hCEC0_8000 | ({30'd0, opc} << 10) | ({27'd0, rn} << 5) | {27'd0, rd};
    endfunction

    // ---- helpers ----
    task automatic chk_bits(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_vec(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(logic [4:0] idx, logic [127:0] val);
        @(negedge clk);
        tp_we = 1'b1; tp_addr = idx; tp_wdata = val;
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic peek(logic [4:0] idx, output logic [127:0] val);
        tp_addr = idx;
        #1;
        val = tp_rdata;
    endtask

    // Offers one word; returns busy in the middle cycle and the outcome pulses.
    task automatic issue(logic [31:0] w, output logic mid_busy, output logic [3:0] fl);
        @(negedge clk);
        insn_valid = 1'b1; insn = w;
        @(negedge clk);
        insn_valid = 1'b0;
        mid_busy = busy;
        @(negedge clk);
        fl = {done, undef, trap, not_mine};
    endtask

    // Runs a legal word and compares the destination with the model.
    task automatic run_legal(string tag, int kind, logic [31:0] w, logic [4:0] rd,
                             logic [127:0] d, n, m);
        logic mb; logic [3:0] fl; logic [127:0] got;
        issue(w, mb, fl);
        chk_bits({tag, " flags"}, fl, F_DONE);
        peek(rd, got);
        chk_vec({tag, " result"}, got, model(kind, d, n, m));
    endtask

    task automatic run_fault(string tag, logic [31:0] w, logic [3:0] exp_fl,
                             logic [4:0] rd, logic [127:0] keep);
        logic mb; logic [3:0] fl; logic [127:0] got;
        issue(w, mb, fl);
        chk_bits({tag, " flags"}, fl, exp_fl);
        peek(rd, got);
        chk_vec({tag, " dest unchanged"}, got, keep);
    endtask

    localparam logic [127:0] V1 = 128'h6a09e667f3bcc908_bb67ae8584caa73b;
    localparam logic [127:0] V2 = 128'h3c6ef372fe94f82b_a54ff53a5f1d36f1;
    localparam logic [127:0] V3 = 128'h510e527fade682d1_9b05688c2b3e6c1f;
    localparam logic [127:0] V4 = 128'h1f83d9abfb41bd6b_5be0cd19137e2179;
    localparam logic [127:0] V5 = 128'hffffffffffffffff_0000000000000001;

    // ---- scenarios ----
    task automatic t_reset;
        chk_bits("R11 reset outcomes", {done, undef, trap, not_mine}, F_NONE);
        chk_bits("R11 reset busy", {3'b0, busy}, 4'b0);
    endtask

    task automatic t_port;
        logic [127:0] g;
        load(5'd31, V5);
        peek(5'd31, g);
        chk_vec("R13 test port readback", g, V5);
    endtask

    task automatic t_round_h;
        logic [127:0] g;
        load(1, V1); load(2, V2); load(3, V3);
        run_legal("R1 R3 round H", 0, enc3(0, 2'd0, 5'd3, 5'd2, 5'd1), 1, V1, V2, V3);
        peek(2, g);
        chk_vec("R3 source untouched", g, V2);
    endtask

    task automatic t_round_h2;
        load(4, V4); load(5, V1); load(6, V5);
        run_legal("R4 round H2", 1, enc3(0, 2'd1, 5'd6, 5'd5, 5'd4), 4, V4, V1, V5);
    endtask

    task automatic t_sch1;
        load(7, V3); load(8, V4); load(9, V2);
        run_legal("R5 schedule 1", 2, enc3(0, 2'd2, 5'd9, 5'd8, 5'd7), 7, V3, V4, V2);
    endtask

    task automatic t_sch0;
        load(10, V2); load(11, V5);
        run_legal("R2 R6 schedule 0", 3, enc2(2'd0, 5'd11, 5'd10), 10, V2, V5, 128'd0);
    endtask

    task automatic t_unalloc;
        load(12, V1); load(13, V2); load(14, V3);
        run_fault("R7 opcode 3", enc3(0, 2'd3, 5'd14, 5'd13, 5'd12), F_UNDEF, 12, V1);
        run_fault("R7 option bit", enc3(1, 2'd0, 5'd14, 5'd13, 5'd12), F_UNDEF, 12, V1);
        run_fault("R7 two-op opcode 1", enc2(2'd1, 5'd13, 5'd12), F_UNDEF, 12, V1);
        run_fault("R7 two-op opcode 3", enc2(2'd3, 5'd13, 5'd12), F_UNDEF, 12, V1);
    endtask

    task automatic t_feature;
        load(15, V4); load(16, V1); load(17, V2);
        feat_en = 1'b0;
        run_fault("R8 feature off three-op", enc3(0, 2'd0, 5'd17, 5'd16, 5'd15), F_UNDEF, 15, V4);
        run_fault("R8 feature off two-op", enc2(2'd0, 5'd16, 5'd15), F_UNDEF, 15, V4);
        simd_ok = 1'b0;
        run_fault("R9 undef beats trap", enc3(0, 2'd1, 5'd17, 5'd16, 5'd15), F_UNDEF, 15, V4);
        feat_en = 1'b1;
        run_fault("R9 access trap", enc3(0, 2'd2, 5'd17, 5'd16, 5'd15), F_TRAP, 15, V4);
        run_fault("R9 access trap two-op", enc2(2'd0, 5'd16, 5'd15), F_TRAP, 15, V4);
        simd_ok = 1'b1;
    endtask

    task automatic t_foreign;
        load(18, V3);
        run_fault("R10 zero word", 32'h0000_0012, F_FOREIGN, 18, V3);
        run_fault("R10 near miss", enc3(0, 2'd0, 5'd1, 5'd2, 5'd18) | 32'h0000_2000,
                  F_FOREIGN, 18, V3);
        run_fault("R10 two-op near miss", enc2(2'd0, 5'd1, 5'd18) | 32'h0001_0000,
                  F_FOREIGN, 18, V3);
    endtask

    task automatic t_alias;
        load(19, V2);
        run_legal("R12 full alias H", 0, enc3(0, 2'd0, 5'd19, 5'd19, 5'd19), 19, V2, V2, V2);
        load(20, V4); load(21, V1);
        run_legal("R12 alias rd=rn schedule 1", 2, enc3(0, 2'd2, 5'd21, 5'd20, 5'd20),
                  20, V4, V4, V1);
    endtask

    task automatic t_busy_ignore;
        logic mb; logic [3:0] fl; logic [127:0] g;
        load(22, V1); load(23, V2); load(24, V3); load(25, V5);
        @(negedge clk);
        insn_valid = 1'b1; insn = enc3(0, 2'd1, 5'd24, 5'd23, 5'd22);
        @(negedge clk);
        mb = busy;
        insn = enc3(0, 2'd0, 5'd24, 5'd23, 5'd25);
        @(negedge clk);
        insn_valid = 1'b0;
        fl = {done, undef, trap, not_mine};
        chk_bits("R11 busy in second cycle", {3'b0, mb}, 4'b0001);
        chk_bits("R11 first word completes", fl, F_DONE);
        peek(22, g);
        chk_vec("R11 first word result", g, model(1, V1, V2, V3));
        @(negedge clk);
        chk_bits("R11 no pulse for ignored word", {done, undef, trap, not_mine}, F_NONE);
        chk_bits("R11 idle after completion", {3'b0, busy}, 4'b0);
        @(negedge clk);
        chk_bits("R11 still no pulse", {done, undef, trap, not_mine}, F_NONE);
        peek(25, g);
        chk_vec("R11 ignored word wrote nothing", g, V5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; insn_valid = 1'b0; insn = '0; feat_en = 1'b1; simd_ok = 1'b1;
        tp_we = 1'b0; tp_addr = '0; tp_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_port();
        t_round_h();
        t_round_h2();
        t_sch1();
        t_sch0();
        t_unalloc();
        t_feature();
        t_foreign();
        t_alias();
        t_busy_ignore();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule